// File: doc/BRIEF.md
# Output Channel Sample FIFO with Low-Water Interrupt

This block is the sample buffer of one analog output channel. The host loads 16-bit samples through a request/acknowledge write port, and each acknowledge takes a fixed number of wait states. A conversion-rate strobe from the channel's timer removes one sample per pulse. Samples come out on a registered data port in the order they were written.

The channel has a run state. A software start request or an external trigger sets it, and the trigger-mode input selects which of the two is accepted. Pops take effect only while the channel runs. A software reset or a hardware reset empties the buffer and stops the channel. A registered interrupt request asks the host for more data. It is active while the enable is set and occupancy is at or below a programmable low-water threshold. A full flag tells the host to stop writing. A write offered while the buffer is full is never acknowledged.

Top module: `chan_sample_fifo`

## Requirements
- R1: A write request held high while the buffer is not full stores `wr_data` at the clock edge that ends the wait states. `wr_ack` is high for exactly one cycle, starting WAIT_STATES+1 rising edges after the first edge that samples the request (with the default of 2 wait states, the ack appears after the third edge). Only one write is accepted per request.
- R2: A write request made while `full` is high gets no `wr_ack` and does not change `level`.
- R3: Samples appear on `rd_data` in write order. `rd_data` takes the popped sample at the clock edge that samples the pop.
- R4: A pop strobe while `running` is low removes nothing.
- R5: A pop strobe while running with the buffer empty removes nothing and sets `underrun`. `underrun` stays high until a software or hardware reset.
- R6: `full` is high exactly when `level` equals DEPTH. One accepted pop clears it.
- R7: One cycle after `irq_en` is high and `level` <= `thresh`, `irq` is high.
- R8: `irq` goes low one cycle after `level` rises above `thresh`, or one cycle after `irq_en` is cleared.
- R9: `start_sw` sets `running` unless `trig_mode` is 2'b11 (external only). The encodings are: 2'b00 software only, 2'b01 and 2'b10 either source, 2'b11 external only.
- R10: `ext_trig` sets `running` unless `trig_mode` is 2'b00.
- R11: `soft_rst` (or `rst_n` low) at an edge sets `level` to 0 and clears `full`, `underrun` and `running`. It also abandons a write in progress without an acknowledge.
- R12: `level` reports the number of stored samples. It rises by one per acknowledged write and falls by one per accepted pop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Hardware reset, active low, asynchronous |
| soft_rst | input | 1 | Synchronous channel reset |
| wr_req | input | 1 | Host write request, held until acknowledged |
| wr_data | input | DW | Sample to store |
| wr_ack | output | 1 | One-cycle write acknowledge |
| trig_mode | input | 2 | Start source selection |
| start_sw | input | 1 | Software start request |
| ext_trig | input | 1 | External trigger |
| pop | input | 1 | Conversion-rate sample strobe |
| irq_en | input | 1 | Interrupt enable |
| thresh | input | CW | Low-water threshold |
| rd_data | output | DW | Most recently popped sample |
| level | output | CW | Stored sample count |
| full | output | 1 | Buffer full |
| running | output | 1 | Channel run state |
| underrun | output | 1 | Sticky empty-pop flag |
| irq | output | 1 | Interrupt request |

## Verification
Read and write pointers are hidden, but if they slip, the scoreboard sees it on `rd_data` on the first pop after the fault. It also shows when the buffer has been filled to DEPTH and drained back. A wrong occupancy counter shows on `level` at once. One cycle later it shows on `irq`, and on `full` at the boundary, because the bench crosses both threshold and depth. A fault in the wait-state counter shows on the first write after reset as a wrong acknowledge cycle. A stuck run state shows as pops that remove nothing, or as a missing `underrun`.

// File: rtl/chan_fifo_pkg.sv
package chan_fifo_pkg;
   typedef enum logic [1:0] {
      TRG_SW_ONLY  = 2'b00,
      TRG_ANY_A    = 2'b01,
      TRG_ANY_B    = 2'b10,
      TRG_EXT_ONLY = 2'b11
   } trig_mode_e;
endpackage

// File: rtl/chan_fifo_store.sv
module chan_fifo_store #(
   parameter int DW    = 16,
   parameter int DEPTH = 64,
   localparam int AW   = $clog2(DEPTH),
   localparam int CW   = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          push,
   input  logic [DW-1:0] din,
   input  logic          pop,
   output logic [DW-1:0] dout,
   output logic [CW-1:0] cnt,
   output logic          full,
   output logic          empty
);
   logic [DW-1:0] mem [DEPTH];
   logic [AW-1:0] wptr, rptr;

   always_ff @(posedge clk) begin
      if (push) mem[wptr] <= din;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wptr <= '0;
         rptr <= '0;
         cnt  <= '0;
         dout <= '0;
      end else if (clr) begin
         wptr <= '0;
         rptr <= '0;
         cnt  <= '0;
      end else begin
         if (push) wptr <= wptr + 1'b1;
         if (pop) begin
            rptr <= rptr + 1'b1;
            dout <= mem[rptr];
         end
         if (push && !pop)      cnt <= cnt + 1'b1;
         else if (pop && !push) cnt <= cnt - 1'b1;
      end
   end

   assign full  = (cnt == CW'(DEPTH));
   assign empty = (cnt == '0);

   a_r2_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      push |-> (!full || pop));
   a_r5_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
      pop |-> !empty);
endmodule

// File: rtl/chan_fifo_wrack.sv
module chan_fifo_wrack #(
   parameter int WAIT_STATES = 2,
   localparam int WSW = (WAIT_STATES < 1) ? 1 : $clog2(WAIT_STATES + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic req,
   input  logic full,
   output logic push,
   output logic ack
);
   generate
      if (WAIT_STATES == 0) begin : g_nowait
         assign push = req && !ack && !full;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)   ack <= 1'b0;
            else if (clr) ack <= 1'b0;
            else          ack <= push;
         end
      end else begin : g_wait
         logic           busy;
         logic [WSW-1:0] ws;
         assign push = busy && (ws == WSW'(WAIT_STATES));
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               busy <= 1'b0;
               ws   <= '0;
               ack  <= 1'b0;
            end else if (clr) begin
               busy <= 1'b0;
               ws   <= '0;
               ack  <= 1'b0;
            end else begin
               ack <= 1'b0;
               if (!busy) begin
                  if (req && !ack && !full) begin
                     busy <= 1'b1;
                     ws   <= WSW'(1);
                  end
               end else if (push) begin
                  busy <= 1'b0;
                  ack  <= 1'b1;
               end else begin
                  ws <= ws + 1'b1;
               end
            end
         end

         a_r1_ack_single: assert property (@(posedge clk) disable iff (!rst_n)
            ack |=> !ack);
         a_r1_ack_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
            (ack && !$past(clr)) |-> $past(busy));
         a_r2_full_blocks: assert property (@(posedge clk) disable iff (!rst_n)
            (!busy && full) |=> !busy);
      end
   endgenerate
endmodule

// File: rtl/chan_fifo_ctl.sv
module chan_fifo_ctl
   import chan_fifo_pkg::*;
#(
   parameter int CW = 7
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic [1:0]    mode,
   input  logic          start_sw,
   input  logic          ext_trig,
   input  logic          pop,
   input  logic          empty,
   input  logic [CW-1:0] cnt,
   input  logic [CW-1:0] thresh,
   input  logic          irq_en,
   output logic          pop_ok,
   output logic          running,
   output logic          underrun,
   output logic          irq
);
   trig_mode_e tm;
   logic       sw_go, ext_go;

   assign tm     = trig_mode_e'(mode);
   assign sw_go  = start_sw && (tm != TRG_EXT_ONLY);
   assign ext_go = ext_trig && (tm != TRG_SW_ONLY);
   assign pop_ok = pop && running && !empty;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         running  <= 1'b0;
         underrun <= 1'b0;
         irq      <= 1'b0;
      end else begin
         irq <= irq_en && (cnt <= thresh);
         if (clr) begin
            running  <= 1'b0;
            underrun <= 1'b0;
         end else begin
            if (sw_go || ext_go)           running  <= 1'b1;
            if (pop && running && empty)   underrun <= 1'b1;
         end
      end
   end

   a_r8_disable_releases: assert property (@(posedge clk) disable iff (!rst_n)
      !irq_en |=> !irq);
   a_r5_underrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (underrun && !clr) |=> underrun);
   a_r11_clear_stops: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (!running && !underrun));
   a_r9_ext_only_gate: assert property (@(posedge clk) disable iff (!rst_n)
      (tm == TRG_EXT_ONLY && !ext_trig && !running) |=> !running);
endmodule

// File: rtl/chan_sample_fifo.sv
module chan_sample_fifo #(
   parameter int DW          = 16,
   parameter int DEPTH       = 64,
   parameter int WAIT_STATES = 2,
   localparam int CW         = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          soft_rst,
   input  logic          wr_req,
   input  logic [DW-1:0] wr_data,
   output logic          wr_ack,
   input  logic [1:0]    trig_mode,
   input  logic          start_sw,
   input  logic          ext_trig,
   input  logic          pop,
   input  logic          irq_en,
   input  logic [CW-1:0] thresh,
   output logic [DW-1:0] rd_data,
   output logic [CW-1:0] level,
   output logic          full,
   output logic          running,
   output logic          underrun,
   output logic          irq
);
   generate
      if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
         $error("DEPTH must be a power of two and at least 2");
      end
      if (DW < 1) begin : g_bad_dw
         $error("DW must be positive");
      end
      if (WAIT_STATES < 0) begin : g_bad_ws
         $error("WAIT_STATES must not be negative");
      end
   endgenerate

   logic push, pop_ok, empty;

   chan_fifo_wrack #(.WAIT_STATES(WAIT_STATES)) u_wrack (
      .clk(clk), .rst_n(rst_n), .clr(soft_rst), .req(wr_req),
      .full(full), .push(push), .ack(wr_ack));

   chan_fifo_store #(.DW(DW), .DEPTH(DEPTH)) u_store (
      .clk(clk), .rst_n(rst_n), .clr(soft_rst), .push(push), .din(wr_data),
      .pop(pop_ok), .dout(rd_data), .cnt(level), .full(full), .empty(empty));

   chan_fifo_ctl #(.CW(CW)) u_ctl (
      .clk(clk), .rst_n(rst_n), .clr(soft_rst), .mode(trig_mode),
      .start_sw(start_sw), .ext_trig(ext_trig), .pop(pop), .empty(empty),
      .cnt(level), .thresh(thresh), .irq_en(irq_en), .pop_ok(pop_ok),
      .running(running), .underrun(underrun), .irq(irq));

   a_r12_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
      level <= CW'(DEPTH));
endmodule

// File: tb/tb_chan_sample_fifo.sv
module tb_chan_sample_fifo;
   localparam int DW = 16, DEPTH = 64, WS = 2;
   localparam int CW = $clog2(DEPTH + 1);

   logic clk = 1'b0, rst_n = 1'b0, soft_rst = 1'b0;
   logic wr_req = 1'b0, start_sw = 1'b0, ext_trig = 1'b0, pop = 1'b0, irq_en = 1'b0;
   logic [DW-1:0] wr_data = '0;
   logic [1:0] trig_mode = 2'b00;
   logic [CW-1:0] thresh = '0;
   logic wr_ack, full, running, underrun, irq;
   logic [DW-1:0] rd_data;
   logic [CW-1:0] level;

   int nchk = 0, nfail = 0;
   bit done = 0, exp_run = 0;
   logic [DW-1:0] q[$];

   always #5 clk = ~clk;

   chan_sample_fifo #(.DW(DW), .DEPTH(DEPTH), .WAIT_STATES(WS)) dut (.*);

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      nchk++;
      if (!ok) begin
         nfail++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // monitor: compares popped samples against the scoreboard queue
   always begin
      bit take;
      logic [DW-1:0] e;
      @(posedge clk);
      take = rst_n && !soft_rst && pop && exp_run && (q.size() > 0);
      if (take) e = q.pop_front();
      @(negedge clk);
      if (take) chk(rd_data == e, "R3 rd_data order", int'(rd_data), int'(e));
   end

   task automatic do_write(input logic [DW-1:0] d, input bit want_ack);
      bit got = 0;
      int lat = 0;
      @(negedge clk);
      wr_data = d;
      wr_req  = 1'b1;
      for (int i = 1; i <= 12; i++) begin
         @(negedge clk);
         if (wr_ack) begin got = 1; lat = i; break; end
      end
      wr_req = 1'b0;
      if (want_ack) begin
         chk(got && lat == WS + 1, "R1 ack latency", lat, WS + 1);
         if (got) q.push_back(d);
      end else begin
         chk(!got, "R2 write while full acked", int'(got), 0);
      end
   endtask

   task automatic do_pop();
      @(negedge clk);
      pop = 1'b1;
      @(negedge clk);
      pop = 1'b0;
   endtask

   task automatic pulse(ref logic s);
      @(negedge clk);
      s = 1'b1;
      @(negedge clk);
      s = 1'b0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         nfail++; nchk++;
         $display("FAIL watchdog expired actual=1 expected=0");
         $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(level == 0 && !full && !running && !underrun && !irq && !wr_ack,
          "R11 reset state", int'(level), 0);

      // writes while stopped, pop ignored
      do_write(16'h1111, 1);
      do_write(16'h2222, 1);
      do_write(16'h3333, 1);
      chk(level == 3, "R12 level after writes", int'(level), 3);
      do_pop();
      chk(level == 3, "R4 pop while stopped", int'(level), 3);

      // start gating
      trig_mode = 2'b11; pulse(start_sw);
      @(negedge clk);
      chk(!running, "R9 sw start in external-only", int'(running), 0);
      trig_mode = 2'b00; pulse(ext_trig);
      @(negedge clk);
      chk(!running, "R10 ext trig in software-only", int'(running), 0);
      pulse(start_sw);
      chk(running, "R9 sw start accepted", int'(running), 1);
      exp_run = 1;

      do_pop(); do_pop(); do_pop();
      chk(level == 0, "R12 level after drain", int'(level), 0);
      chk(!underrun, "R5 no underrun yet", int'(underrun), 0);
      do_pop();
      chk(underrun && level == 0, "R5 empty pop sets underrun", int'(underrun), 1);
      repeat (3) @(negedge clk);
      chk(underrun, "R5 underrun sticky", int'(underrun), 1);

      pulse(soft_rst); exp_run = 0;
      chk(!running && !underrun && level == 0, "R11 soft reset", int'(running), 0);

      // interrupt threshold
      thresh = CW'(2); irq_en = 1'b1;
      @(negedge clk); @(negedge clk);
      chk(irq, "R7 irq at level 0", int'(irq), 1);
      do_write(16'hA001, 1);
      do_write(16'hA002, 1);
      @(negedge clk);
      chk(irq, "R7 irq at level equal thresh", int'(irq), 1);
      do_write(16'hA003, 1);
      @(negedge clk);
      chk(!irq, "R8 irq released above thresh", int'(irq), 0);
      trig_mode = 2'b10; pulse(ext_trig);
      chk(running, "R10 ext trig accepted", int'(running), 1);
      exp_run = 1;
      do_pop();
      @(negedge clk);
      chk(irq, "R7 irq after pop to thresh", int'(irq), 1);
      irq_en = 1'b0;
      @(negedge clk);
      chk(!irq, "R8 irq released by disable", int'(irq), 0);

      // fill to full (pops gated by stopping the channel)
      exp_run = 0;
      pulse(soft_rst);
      q.delete();
      for (int i = 0; i < DEPTH; i++) begin
         do_write(DW'(16'h5000 + i * 7), 1);
         if (i == DEPTH - 2) chk(!full, "R6 not full below depth", int'(full), 0);
      end
      chk(full && level == CW'(DEPTH), "R6 full at depth", int'(level), DEPTH);
      do_write(16'hDEAD, 0);
      chk(level == CW'(DEPTH), "R2 level unchanged", int'(level), DEPTH);
      trig_mode = 2'b01; pulse(start_sw);
      exp_run = 1;
      do_pop();
      chk(!full && level == CW'(DEPTH - 1), "R6 pop clears full", int'(level), DEPTH - 1);
      for (int i = 0; i < DEPTH - 1; i++) do_pop();
      chk(level == 0 && !underrun, "R12 drained", int'(level), 0);

      // soft reset abandons a write in progress
      begin
         bit seen = 0;
         @(negedge clk);
         wr_data = 16'hBEEF; wr_req = 1'b1;
         @(negedge clk);
         soft_rst = 1'b1; wr_req = 1'b0;
         @(negedge clk);
         soft_rst = 1'b0; exp_run = 0;
         for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            if (wr_ack) seen = 1;
         end
         chk(!seen && level == 0, "R11 write abandoned", int'(seen), 0);
      end

      // hardware reset
      do_write(16'h0101, 1);
      do_write(16'h0202, 1);
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      q.delete();
      @(negedge clk);
      chk(level == 0 && !full && !running, "R11 hardware reset", int'(level), 0);

      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
   end
endmodule